// File: doc/BRIEF.md
# Two-Detector Coincidence Event Selector

This block decides, cycle by cycle, whether a pair of detector hits forms one usable scattering event. One trigger line comes from the absorbing detector. A bank of nineteen trigger lines comes from the pixelated scattering detector. A rising edge on the absorber line opens a collection window of programmable length. Every scatter channel that shows a rising edge during that window is recorded in a hit mask.

When the window closes, the mask must hold exactly one channel. An empty mask or a mask with several channels ends the attempt with a purge. A mask with a single channel starts a guard interval of programmable length. Any further trigger from either detector during the guard interval also ends in a purge. If the guard interval passes quietly, the block pulses its accept output and presents the channel number alongside the pulse.

After every accept or purge, the block rests for one cycle before it looks for the next absorber edge. Four running counters report the number of accepted events and the number of purges for each of the three reasons. The block only decides. The surrounding logic moves the event data.

Top module: `coin_event_sel`

## Requirements
- R1: While reset is high and in the first cycle after it, `accept_o`, `purge_o` and `chan_idx_o` are zero and all four counters read zero.
- R2: When no absorber edge has opened a window, scatter trigger edges cause no pulse and leave every counter unchanged.
- R3: The window takes D = max(`drift_len_i`, 1) cycles. Scatter edges first sampled on the same clock edge as the absorber edge, or on any of the D edges after it, are counted. Later edges are not counted.
- R4: If the window closes with no scatter channel recorded, the block pulses `purge_o` and increments `n_purge_empty_o`.
- R5: If two or more distinct scatter channels are recorded, whether in the same cycle or in different cycles, the block pulses `purge_o` and increments `n_purge_multi_o`. Repeated edges on one channel count as one channel.
- R6: With a single channel recorded, any absorber or scatter edge sampled during the following Q = max(`guard_len_i`, 1) cycles causes a `purge_o` pulse one cycle after that edge is sampled, and increments `n_purge_guard_o`. Edges sampled after the guard interval do not affect the event.
- R7: An accept is a one-cycle `accept_o` pulse. During the pulse, `chan_idx_o` carries the bit position (0 to 18) of the recorded channel in `scat_trig_i`, and `n_accept_o` increments. At all other times `chan_idx_o` is zero. `accept_o` and `purge_o` are never high together, and each pulse lasts one cycle.
- R8: If the absorber edge is first sampled on clock edge E, the window-end purge is visible after edge E+D+1 and the accept after edge E+D+Q+1.
- R9: Only rising edges count. A scatter line already high before the window opens adds no channel while it stays high.
- R10: A second absorber edge inside the collection window has no effect on the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gamma_trig_i | input | 1 | Trigger from the absorbing detector |
| scat_trig_i | input | N_SCAT | Triggers from the scatter channels, bit i = channel i |
| drift_len_i | input | TMR_W | Collection window length in cycles (0 acts as 1) |
| guard_len_i | input | TMR_W | Guard interval length in cycles (0 acts as 1) |
| accept_o | output | 1 | One-cycle pulse for an accepted event |
| purge_o | output | 1 | One-cycle pulse for a rejected attempt |
| chan_idx_o | output | IDX_W | Scatter channel of the accepted event, valid with accept_o |
| n_accept_o | output | CNT_W | Count of accepted events |
| n_purge_empty_o | output | CNT_W | Count of purges with no scatter channel |
| n_purge_multi_o | output | CNT_W | Count of purges with several scatter channels |
| n_purge_guard_o | output | CNT_W | Count of purges from a trigger in the guard interval |

## Verification
A wrong state or a miscounted timer shows up as a pulse in the wrong cycle. A purge arrives after edge E+D+1 only when the timing is correct, and an accept after E+D+Q+1 only when both intervals are counted correctly. A hit mask that was not cleared, or that dropped a channel, shows up in the same event as the wrong pulse type or a wrong `chan_idx_o`. A purge charged to the wrong reason shows up at once on the counters, which are compared after every event.

// File: rtl/coin_pkg.sv
package coin_pkg;

    localparam int SCAT_CH     = 19;
    localparam int TMR_W_DEF   = 8;
    localparam int CNT_W_DEF   = 16;
    localparam int N_OUTCOMES  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRIFT,
        ST_GUARD,
        ST_HOLD
    } coin_state_e;

    typedef enum logic [2:0] {
        OC_NONE,
        OC_ACCEPT,
        OC_EMPTY,
        OC_MULTI,
        OC_GUARD
    } coin_outcome_e;

    function automatic logic oc_is_purge(coin_outcome_e oc);
        return (oc == OC_EMPTY) || (oc == OC_MULTI) || (oc == OC_GUARD);
    endfunction

    // Tally slot for an outcome: 0 accept, 1 empty, 2 multi, 3 guard.
    function automatic logic [N_OUTCOMES-1:0] oc_slot(coin_outcome_e oc);
        logic [N_OUTCOMES-1:0] s;
        s = '0;
        case (oc)
            OC_ACCEPT: s[0] = 1'b1;
            OC_EMPTY:  s[1] = 1'b1;
            OC_MULTI:  s[2] = 1'b1;
            OC_GUARD:  s[3] = 1'b1;
            default:   s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/coin_edge_det.sv
module coin_edge_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] smp_q;
    logic [W-1:0] old_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                smp_q[g] <= 1'b0;
                old_q[g] <= 1'b0;
            end else begin
                smp_q[g] <= lvl_i[g];
                old_q[g] <= smp_q[g];
            end
        end
        assign rise_o[g] = smp_q[g] & ~old_q[g];
    end
endmodule

// File: rtl/coin_win_timer.sv
module coin_win_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    input  logic         step_i,
    output logic         last_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] len_eff;

    assign len_eff = (len_i == '0) ? W'(1) : len_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_eff;
        end else if (step_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/coin_hit_eval.sv
module coin_hit_eval #(
    parameter int N     = 19,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     hits_i,
    output logic             none_o,
    output logic             one_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [N-1:0] low_cleared;

    assign low_cleared = hits_i & (hits_i - 1'b1);
    assign none_o      = (hits_i == '0);
    assign one_o       = !none_o && (low_cleared == '0);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/coin_tally.sv
module coin_tally #(
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  coin_pkg::coin_outcome_e oc_i,
    output logic [CNT_W-1:0]       n_accept_o,
    output logic [CNT_W-1:0]       n_empty_o,
    output logic [CNT_W-1:0]       n_multi_o,
    output logic [CNT_W-1:0]       n_guard_o
);
    import coin_pkg::*;

    logic [N_OUTCOMES-1:0]            bump;
    logic [N_OUTCOMES-1:0][CNT_W-1:0] cnt_q;

    assign bump = oc_slot(oc_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            for (int k = 0; k < N_OUTCOMES; k++) begin
                if (bump[k]) cnt_q[k] <= cnt_q[k] + 1'b1;
            end
        end
    end

    assign n_accept_o = cnt_q[0];
    assign n_empty_o  = cnt_q[1];
    assign n_multi_o  = cnt_q[2];
    assign n_guard_o  = cnt_q[3];
endmodule

// File: rtl/coin_event_sel.sv
module coin_event_sel #(
    parameter int N_SCAT = coin_pkg::SCAT_CH,
    parameter int TMR_W  = coin_pkg::TMR_W_DEF,
    parameter int CNT_W  = coin_pkg::CNT_W_DEF,
    localparam int IDX_W = $clog2(N_SCAT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gamma_trig_i,
    input  logic [N_SCAT-1:0] scat_trig_i,
    input  logic [TMR_W-1:0]  drift_len_i,
    input  logic [TMR_W-1:0]  guard_len_i,
    output logic              accept_o,
    output logic              purge_o,
    output logic [IDX_W-1:0]  chan_idx_o,
    output logic [CNT_W-1:0]  n_accept_o,
    output logic [CNT_W-1:0]  n_purge_empty_o,
    output logic [CNT_W-1:0]  n_purge_multi_o,
    output logic [CNT_W-1:0]  n_purge_guard_o
);
    import coin_pkg::*;

    // Edge pulses
    logic              gam_p;
    logic [N_SCAT-1:0] scat_p;

    coin_edge_det #(.W(1)) u_gam_edge (
        .clk(clk), .rst(rst), .lvl_i(gamma_trig_i), .rise_o(gam_p)
    );
    coin_edge_det #(.W(N_SCAT)) u_scat_edge (
        .clk(clk), .rst(rst), .lvl_i(scat_trig_i), .rise_o(scat_p)
    );

    // State
    coin_state_e       st_q, st_n;
    logic [N_SCAT-1:0] mask_q, mask_n, mask_acc;
    logic [IDX_W-1:0]  idx_q, idx_n;
    logic              accept_q, purge_q;
    logic [IDX_W-1:0]  chan_q;
    coin_outcome_e     oc;

    // Timer control
    logic             tmr_load, tmr_step, tmr_last;
    logic [TMR_W-1:0] tmr_len;

    coin_win_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .load_i(tmr_load), .len_i(tmr_len),
        .step_i(tmr_step), .last_o(tmr_last)
    );

    // Hit evaluation over the mask including this cycle's edges
    logic             hv_none, hv_one;
    logic [IDX_W-1:0] hv_idx;

    assign mask_acc = mask_q | scat_p;

    coin_hit_eval #(.N(N_SCAT), .IDX_W(IDX_W)) u_eval (
        .hits_i(mask_acc), .none_o(hv_none), .one_o(hv_one), .idx_o(hv_idx)
    );

    always_comb begin
        st_n     = st_q;
        mask_n   = mask_q;
        idx_n    = idx_q;
        oc       = OC_NONE;
        tmr_load = 1'b0;
        tmr_step = 1'b0;
        tmr_len  = drift_len_i;
        case (st_q)
            ST_IDLE: begin
                if (gam_p) begin
                    st_n     = ST_DRIFT;
                    mask_n   = scat_p;
                    tmr_load = 1'b1;
                end
            end
            ST_DRIFT: begin
                mask_n = mask_acc;
                if (tmr_last) begin
                    if (hv_one) begin
                        st_n     = ST_GUARD;
                        idx_n    = hv_idx;
                        tmr_load = 1'b1;
                        tmr_len  = guard_len_i;
                    end else begin
                        st_n = ST_HOLD;
                        oc   = hv_none ? OC_EMPTY : OC_MULTI;
                    end
                end else begin
                    tmr_step = 1'b1;
                end
            end
            ST_GUARD: begin
                if (gam_p || (scat_p != '0)) begin
                    st_n = ST_HOLD;
                    oc   = OC_GUARD;
                end else if (tmr_last) begin
                    st_n = ST_HOLD;
                    oc   = OC_ACCEPT;
                end else begin
                    tmr_step = 1'b1;
                end
            end
            default: begin
                st_n   = ST_IDLE;
                mask_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            mask_q   <= '0;
            idx_q    <= '0;
            accept_q <= 1'b0;
            purge_q  <= 1'b0;
            chan_q   <= '0;
        end else begin
            st_q     <= st_n;
            mask_q   <= mask_n;
            idx_q    <= idx_n;
            accept_q <= (oc == OC_ACCEPT);
            purge_q  <= oc_is_purge(oc);
            chan_q   <= (oc == OC_ACCEPT) ? idx_q : '0;
        end
    end

    coin_tally #(.CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst(rst), .oc_i(oc),
        .n_accept_o(n_accept_o), .n_empty_o(n_purge_empty_o),
        .n_multi_o(n_purge_multi_o), .n_guard_o(n_purge_guard_o)
    );

    assign accept_o   = accept_q;
    assign purge_o    = purge_q;
    assign chan_idx_o = chan_q;
endmodule

// File: rtl/coin_event_sel_chk.sv
module coin_event_sel_chk #(
    parameter int N_SCAT = 19,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             accept_o,
    input logic             purge_o,
    input logic [IDX_W-1:0] chan_idx_o,
    input logic [CNT_W-1:0] n_accept_o,
    input logic [CNT_W-1:0] n_purge_empty_o,
    input logic [CNT_W-1:0] n_purge_multi_o,
    input logic [CNT_W-1:0] n_purge_guard_o
);
    logic [CNT_W+1:0] purge_total;
    assign purge_total = {2'b00, n_purge_empty_o} + {2'b00, n_purge_multi_o}
                       + {2'b00, n_purge_guard_o};

    a_r7_accept_single: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> !accept_o);
    a_r7_purge_single: assert property (@(posedge clk) disable iff (rst)
        purge_o |=> !purge_o);
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(accept_o && purge_o));
    a_r7_idx_quiet: assert property (@(posedge clk) disable iff (rst)
        !accept_o |-> chan_idx_o == '0);
    a_r7_idx_range: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> chan_idx_o < IDX_W'(N_SCAT));
    a_r7_accept_count: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> n_accept_o == $past(n_accept_o) + 1'b1);
    a_r2_accept_count_hold: assert property (@(posedge clk) disable iff (rst)
        !accept_o |-> $stable(n_accept_o));
    a_r6_purge_count: assert property (@(posedge clk) disable iff (rst)
        purge_o |-> purge_total == $past(purge_total) + 1'b1);
    a_r2_purge_count_hold: assert property (@(posedge clk) disable iff (rst)
        !purge_o |-> $stable(purge_total));
endmodule

bind coin_event_sel coin_event_sel_chk #(
    .N_SCAT(N_SCAT), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .accept_o(accept_o), .purge_o(purge_o),
    .chan_idx_o(chan_idx_o), .n_accept_o(n_accept_o),
    .n_purge_empty_o(n_purge_empty_o), .n_purge_multi_o(n_purge_multi_o),
    .n_purge_guard_o(n_purge_guard_o)
);

// File: tb/tb_coin_event_sel.sv
module tb_coin_event_sel;
    localparam int NS = 19;
    localparam int K_ACC = 1, K_EMPTY = 2, K_MULTI = 3, K_GUARD = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          gamma_trig = 1'b0;
    logic [NS-1:0] scat_trig = '0;
    logic [7:0]    drift_len = 8'd10;
    logic [7:0]    guard_len = 8'd6;
    logic          accept, purge;
    logic [4:0]    chan_idx;
    logic [15:0]   n_acc, n_emp, n_mul, n_grd;

    coin_event_sel dut (
        .clk(clk), .rst(rst), .gamma_trig_i(gamma_trig), .scat_trig_i(scat_trig),
        .drift_len_i(drift_len), .guard_len_i(guard_len),
        .accept_o(accept), .purge_o(purge), .chan_idx_o(chan_idx),
        .n_accept_o(n_acc), .n_purge_empty_o(n_emp),
        .n_purge_multi_o(n_mul), .n_purge_guard_o(n_grd)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    int e_acc = 0, e_emp = 0, e_mul = 0, e_grd = 0;
    logic [NS-1:0] hold_mask = '0;
    bit finished = 0;

    typedef struct {
        int    kind;
        int    idx;
        int    cyc;
        string req;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_counters(input string req);
        chk(n_acc == 16'(e_acc), req, "accept count", int'(n_acc), e_acc);
        chk(n_emp == 16'(e_emp), req, "empty purge count", int'(n_emp), e_emp);
        chk(n_mul == 16'(e_mul), req, "multi purge count", int'(n_mul), e_mul);
        chk(n_grd == 16'(e_grd), req, "guard purge count", int'(n_grd), e_grd);
    endtask

    // Monitor: pops expected outcomes as pulses appear
    always @(posedge clk) begin
        #2;
        if (!rst && (accept || purge)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2", "unexpected pulse", int'(accept), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.kind == K_ACC) begin
                    chk(accept && !purge, e.req, "accept pulse", int'(accept), 1);
                    chk(int'(chan_idx) == e.idx, e.req, "channel index",
                        int'(chan_idx), e.idx);
                end else begin
                    chk(purge && !accept, e.req, "purge pulse", int'(purge), 1);
                    chk(chan_idx == '0, "R7", "index during purge", int'(chan_idx), 0);
                end
                chk(cyc == e.cyc, "R8", "pulse cycle", cyc, e.cyc);
            end
        end
    end

    // Driver: models the expected outcome, then plays the stimulus.
    // Offsets are in cycles after the absorber edge; -1 disables.
    task automatic evt(input int dl, input int gl, input int c1, input int o1,
                       input int c2, input int o2, input int go, input string req);
        int d, q, grd_at, cnt, idx0, c0;
        logic [NS-1:0] m;
        exp_t e;
        d = (dl == 0) ? 1 : dl;
        q = (gl == 0) ? 1 : gl;
        m = '0;
        grd_at = -1;
        if (c1 >= 0 && o1 >= 0 && o1 <= d) m[c1] = 1'b1;
        if (c2 >= 0 && o2 >= 0 && o2 <= d) m[c2] = 1'b1;
        if (c1 >= 0 && o1 > d && o1 <= d + q) grd_at = o1;
        if (c2 >= 0 && o2 > d && o2 <= d + q && (grd_at < 0 || o2 < grd_at)) grd_at = o2;
        if (go > d && go <= d + q && (grd_at < 0 || go < grd_at)) grd_at = go;
        cnt = $countones(m);
        idx0 = 0;
        for (int i = NS - 1; i >= 0; i--) if (m[i]) idx0 = i;
        @(negedge clk);
        drift_len = 8'(dl);
        guard_len = 8'(gl);
        @(negedge clk);
        c0 = cyc;
        e.req = req;
        e.idx = 0;
        if (cnt == 0) begin
            e.kind = K_EMPTY; e.cyc = c0 + d + 2; e_emp++;
        end else if (cnt > 1) begin
            e.kind = K_MULTI; e.cyc = c0 + d + 2; e_mul++;
        end else if (grd_at >= 0) begin
            e.kind = K_GUARD; e.cyc = c0 + grd_at + 2; e_grd++;
        end else begin
            e.kind = K_ACC; e.idx = idx0; e.cyc = c0 + d + q + 2; e_acc++;
        end
        sb.push_back(e);
        for (int t = 0; t <= d + q + 5; t++) begin
            logic [NS-1:0] s;
            s = hold_mask;
            if (c1 >= 0 && o1 == t) s[c1] = 1'b1;
            if (c2 >= 0 && o2 == t) s[c2] = 1'b1;
            scat_trig = s;
            gamma_trig = (t == 0) || (t == go);
            @(negedge clk);
        end
        scat_trig = hold_mask;
        gamma_trig = 1'b0;
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, req, "outcome delivered", sb.size(), 0);
        chk_counters(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!accept && !purge && chan_idx == '0, "R1", "outputs in reset",
            int'({accept, purge}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!accept && !purge && chan_idx == '0, "R1", "outputs after reset",
            int'({accept, purge}), 0);
        chk_counters("R1");

        // R2: scatter edges with no absorber edge
        for (int k = 0; k < 4; k++) begin
            scat_trig = NS'(1) << (k * 4);
            @(negedge clk);
            scat_trig = '0;
            @(negedge clk);
        end
        repeat (20) @(negedge clk);
        chk(!accept && !purge, "R2", "no pulse while idle", int'({accept, purge}), 0);
        chk_counters("R2");

        evt(10, 6,  5, 3,  -1, -1, -1, "R7");   // plain accept
        evt(10, 6,  0, 0,  -1, -1, -1, "R3");   // same cycle as absorber
        evt(10, 6, 18, 10, -1, -1, -1, "R3");   // last cycle of window
        evt(10, 6,  2, 11, -1, -1, -1, "R3");   // just after window -> empty
        evt(10, 6, -1, -1, -1, -1, -1, "R4");   // nothing at all
        evt(10, 6,  1, 4,   9, 4,  -1, "R5");   // two channels same cycle
        evt(10, 6,  3, 1,  12, 8,  -1, "R5");   // two channels apart
        evt(10, 6,  6, 1,   6, 5,  -1, "R9");   // one channel twice
        evt(10, 6,  7, 2,   8, 11, -1, "R6");   // scatter at guard start
        evt(10, 6,  7, 2,  -1, -1, 16, "R6");   // absorber at guard end
        evt(10, 6,  7, 2,   8, 17, -1, "R6");   // just after guard -> accept
        evt(10, 6, 11, 3,  -1, -1, 5,  "R10");  // second absorber in window
        evt(0,  0,  4, 1,  -1, -1, -1, "R3");   // zero lengths act as one
        evt(3,  4,  4, 4,  -1, -1, -1, "R3");   // short window missed
        evt(3,  4, 14, 3,  -1, -1, -1, "R8");   // short window latency

        // R9: a line held high across the window adds no channel
        @(negedge clk);
        hold_mask = '0;
        hold_mask[4] = 1'b1;
        scat_trig = hold_mask;
        repeat (4) @(negedge clk);
        evt(10, 6, 13, 2, -1, -1, -1, "R9");
        hold_mask = '0;
        scat_trig = '0;
        repeat (4) @(negedge clk);
        chk_counters("R2");

        finished = 1;
    end

    initial begin
        fork
            begin
                wait (finished);
            end
            begin
                repeat (100000) @(posedge clk);
                chk(1'b0, "R1", "watchdog expired", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule